// File: doc/BRIEF.md
# Three-Channel Transition-Minimized Link Encoder

This block turns a pixel-clock-synchronous stream of 24-bit pixels, a data-enable flag and sync/control bits into three 10-bit characters per clock, one for each serial lane of a transition-minimized differential video link. During active video (`de` high) each lane encodes one colour byte in two stages. The first stage chains the bits with XOR or XNOR to cut the number of transitions. The second stage may invert the low eight bits so that the lane's long-run count of ones and zeros stays close to equal. Each lane tracks its own running disparity.

During blanking (`de` low) every lane sends one of four fixed control characters, selected by a two-bit code. Lane 0 carries the two sync bits. Lanes 1 and 2 carry the auxiliary control bits, which pass through only while vertical sync is asserted. The top bit of the lane 2 code comes from internal logic; because ciphering lies outside this block, that bit is tied low. All three lanes have the same two-clock latency, so a pixel's three characters leave together. Serialization and line drivers follow this block and are not part of it.

Top module: `tmds_link_encoder`

## Requirements
- R1: A synchronous active-high `rst` clears every lane's disparity to zero and drives all three outputs to 1101010100 (tx[9:0]) until the pipeline refills.
- R2: Stage 1 uses XNOR chaining when the byte holds more than four ones, or exactly four ones with bit 0 clear; otherwise it uses XOR chaining. Bit 0 of the word is the byte's bit 0, and word bit 8 is 1 for XOR and 0 for XNOR.
- R3: Output bit 9 set means the low eight bits are the inverted stage-1 bits, and output bit 8 is stage-1 bit 8. When the disparity is zero or the word is balanced, bit 9 equals the inverse of stage-1 bit 8. Otherwise bit 9 is set exactly when the disparity and the word's ones-minus-zeros have the same sign.
- R4: During active video, each lane's disparity grows by (ones − zeros) of the 10-bit character it sends.
- R5: Control code (C1,C0) maps to 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011, written tx[9:0].
- R6: A cycle with `de` low clears the lane's disparity, so the first pixel after blanking is encoded from a disparity of zero.
- R7: While `de` is high, pix[7:0] is encoded on `tx0`, pix[15:8] on `tx1` and pix[23:16] on `tx2`.
- R8: While `de` is low, lane 0 uses (C1,C0) = (`vsync`,`hsync`).
- R9: While `de` is low and `vsync` is high, lane 1 uses (C1,C0) = (`ctl1`,0) and lane 2 uses (internal bit = 0, `ctl2`). While `vsync` is low, both lanes use code 00.
- R10: Inputs sampled at a clock edge appear on all three outputs after the following edge, a latency of two clocks on every lane.
- R11: While `de` is high, `hsync`, `vsync`, `ctl1` and `ctl2` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| de | input | 1 | Active-video flag |
| pix | input | 24 | Pixel: red 23:16, green 15:8, blue 7:0 |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| ctl1 | input | 1 | Auxiliary control bit for lane 1 |
| ctl2 | input | 1 | Auxiliary control bit for lane 2 |
| tx0 | output | 10 | Lane 0 character |
| tx1 | output | 10 | Lane 1 character |
| tx2 | output | 10 | Lane 2 character |

## Verification
The bench sends every byte value through each lane on a long unbroken active run, so the four-ones tie in stage 1 and both signs of disparity are reached. A wrong tie rule or a flipped sign test changes characters on that run, and a disparity update that is off shows up as a wrong inversion several pixels later. It walks all sync and control combinations during blanking, with and without `vsync`, which catches swapped code bits or auxiliary bits that leak outside vertical blanking. It also chops the active runs with short blanks while toggling sync during active video. A disparity that survives a blank, or sync that disturbs data characters, then shows up on the first pixel of the next run.

// File: rtl/tmds_pkg.sv
`timescale 1ns/1ps
package tmds_pkg;
    localparam int BYTE_W = 8;
    localparam int CHAR_W = 10;
    localparam int LANES  = 3;

    typedef struct packed {
        logic              de;
        logic [BYTE_W:0]   qm;
        logic [1:0]        ctl;
    } s1_t;

    function automatic logic [CHAR_W-1:0] ctl_char(input logic [1:0] code);
        case (code)
            2'b00:   return 10'b1101010100;
            2'b01:   return 10'b0010101011;
            2'b10:   return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] char_decode(input logic [CHAR_W-1:0] ch);
        logic [BYTE_W-1:0] d;
        logic [BYTE_W-1:0] b;
        d = ch[9] ? ~ch[BYTE_W-1:0] : ch[BYTE_W-1:0];
        b[0] = d[0];
        for (int i = 1; i < BYTE_W; i++)
            b[i] = ch[8] ? (d[i] ^ d[i-1]) : ~(d[i] ^ d[i-1]);
        return b;
    endfunction
endpackage

// File: rtl/tmds_ctl_router.sv
`timescale 1ns/1ps
module tmds_ctl_router
    import tmds_pkg::*;
(
    input  logic                  hsync,
    input  logic                  vsync,
    input  logic                  ctl1,
    input  logic                  ctl2,
    output logic [LANES-1:0][1:0] lane_ctl
);
    // Top code bit of lane 2 comes from inside; no cipher here, so it idles low.
    localparam logic LANE2_HI = 1'b0;

    always_comb begin
        lane_ctl[0] = {vsync, hsync};
        lane_ctl[1] = vsync ? {ctl1, 1'b0}     : 2'b00;
        lane_ctl[2] = vsync ? {LANE2_HI, ctl2} : 2'b00;
    end
endmodule

// File: rtl/tmds_chan_enc.sv
`timescale 1ns/1ps
module tmds_chan_enc
    import tmds_pkg::*;
#(
    parameter int DISP_W = 6
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              de,
    input  logic [BYTE_W-1:0] data,
    input  logic [1:0]        ctl,
    output logic [CHAR_W-1:0] tx
);
    typedef struct packed {
        s1_t                      s1;
        logic [CHAR_W-1:0]        tx;
        logic signed [DISP_W-1:0] disp;
    } st_t;

    st_t st_d, st_q;

    logic [3:0]               n_in, n_qm, n_tx;
    logic                     use_xnor;
    logic [BYTE_W:0]          qm;
    logic signed [DISP_W-1:0] bal, delta;
    logic                     invert;

    always_comb begin
        st_d = st_q;

        // stage 1: transition reduction
        n_in     = 4'($countones(data));
        use_xnor = (n_in > 4'd4) || ((n_in == 4'd4) && !data[0]);
        qm[0]    = data[0];
        for (int i = 1; i < BYTE_W; i++)
            qm[i] = use_xnor ? ~(qm[i-1] ^ data[i]) : (qm[i-1] ^ data[i]);
        qm[BYTE_W] = !use_xnor;
        st_d.s1.de  = de;
        st_d.s1.qm  = qm;
        st_d.s1.ctl = ctl;

        // stage 2: balance selection
        n_qm = 4'($countones(st_q.s1.qm[BYTE_W-1:0]));
        bal  = $signed(DISP_W'({n_qm, 1'b0})) - $signed(DISP_W'(BYTE_W));
        if (st_q.disp == 0 || bal == 0)
            invert = !st_q.s1.qm[BYTE_W];
        else
            invert = (st_q.disp[DISP_W-1] == bal[DISP_W-1]);

        if (st_q.s1.de)
            st_d.tx = {invert, st_q.s1.qm[BYTE_W],
                       invert ? ~st_q.s1.qm[BYTE_W-1:0] : st_q.s1.qm[BYTE_W-1:0]};
        else
            st_d.tx = ctl_char(st_q.s1.ctl);

        n_tx  = 4'($countones(st_d.tx));
        delta = $signed(DISP_W'({n_tx, 1'b0})) - $signed(DISP_W'(CHAR_W));
        st_d.disp = st_q.s1.de ? (st_q.disp + delta) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.s1   <= '0;
            st_q.tx   <= ctl_char(2'b00);
            st_q.disp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx = st_q.tx;

    p_ctl_char_r5: assert property (@(posedge clk) disable iff (rst)
        !st_q.s1.de |=> (st_q.tx == 10'b1101010100 || st_q.tx == 10'b0010101011 ||
                         st_q.tx == 10'b0101010100 || st_q.tx == 10'b1010101011));

    p_disp_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !st_q.s1.de |=> (st_q.disp == 0));

    p_disp_even_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.disp[0] == 1'b0);

    p_flag_carry_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.s1.de |=> (st_q.tx[8] == $past(st_q.s1.qm[BYTE_W])));
endmodule

// File: rtl/tmds_link_encoder.sv
`timescale 1ns/1ps
module tmds_link_encoder
    import tmds_pkg::*;
#(
    parameter int DISP_W = 6
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     de,
    input  logic [LANES*BYTE_W-1:0]  pix,
    input  logic                     hsync,
    input  logic                     vsync,
    input  logic                     ctl1,
    input  logic                     ctl2,
    output logic [CHAR_W-1:0]        tx0,
    output logic [CHAR_W-1:0]        tx1,
    output logic [CHAR_W-1:0]        tx2
);
    logic [LANES-1:0][1:0]        lane_ctl;
    logic [LANES-1:0][CHAR_W-1:0] lane_tx;

    tmds_ctl_router u_router (
        .hsync    (hsync),
        .vsync    (vsync),
        .ctl1     (ctl1),
        .ctl2     (ctl2),
        .lane_ctl (lane_ctl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tmds_chan_enc #(.DISP_W(DISP_W)) u_enc (
            .clk  (clk),
            .rst  (rst),
            .de   (de),
            .data (pix[g*BYTE_W +: BYTE_W]),
            .ctl  (lane_ctl[g]),
            .tx   (lane_tx[g])
        );
    end

    assign tx0 = lane_tx[0];
    assign tx1 = lane_tx[1];
    assign tx2 = lane_tx[2];

    // cycles since reset, so two-deep history checks start on clean samples
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else     age_q <= age_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        p_roundtrip_r7: assert property (@(posedge clk) disable iff (rst)
            (age_q == 2'd3 && $past(de, 2)) |->
                (char_decode(lane_tx[g]) == $past(pix[g*BYTE_W +: BYTE_W], 2)));
    end

    p_sync_lane_r10: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && !$past(de, 2)) |->
            (tx0 == ctl_char({$past(vsync, 2), $past(hsync, 2)})));
endmodule

// File: tb/tmds_link_encoder_test.sv
`timescale 1ns/1ps
module tmds_link_encoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        de = 1'b0, hsync = 1'b0, vsync = 1'b0, ctl1 = 1'b0, ctl2 = 1'b0;
    logic [23:0] pix = '0;
    logic [9:0]  tx0, tx1, tx2;

    always #4 clk = ~clk;

    tmds_link_encoder uut (
        .clk(clk), .rst(rst), .de(de), .pix(pix), .hsync(hsync), .vsync(vsync),
        .ctl1(ctl1), .ctl2(ctl2), .tx0(tx0), .tx1(tx1), .tx2(tx2)
    );

    int         n_chk = 0, n_fail = 0;
    int         disp [3] = '{0, 0, 0};
    logic [9:0] e1 [3], e2 [3];
    string      t1, t2;
    logic       after_blank = 1'b1;

    function automatic logic [9:0] ref_ctl(input logic [1:0] c);
        case (c)
            2'b00:   return 10'b1101010100;
            2'b01:   return 10'b0010101011;
            2'b10:   return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    function automatic logic [9:0] ref_enc(input logic [7:0] d, input int run);
        logic [7:0] w;
        logic       xn, inv;
        int         ones, b;
        ones = $countones(d);
        xn   = (ones > 4) || (ones == 4 && d[0] == 1'b0);
        w[0] = d[0];
        for (int i = 1; i < 8; i++) w[i] = xn ? ~(w[i-1] ^ d[i]) : (w[i-1] ^ d[i]);
        b = 2 * $countones(w) - 8;
        if (run == 0 || b == 0) inv = xn;
        else                    inv = ((run > 0) == (b > 0));
        return {inv, ~xn, inv ? ~w : w};
    endfunction

    task automatic chk(input string tag, input int lane, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s lane %0d actual %b expected %b", tag, lane, act, exp);
        end
    endtask

    task automatic step(input logic d, input logic [23:0] p, input logic hs, input logic vs,
                        input logic c1, input logic c2);
        @(negedge clk);
        chk(t2, 0, tx0, e2[0]);
        chk(t2, 1, tx1, e2[1]);
        chk(t2, 2, tx2, e2[2]);
        e2 = e1;
        t2 = t1;
        if (d) begin
            for (int k = 0; k < 3; k++) begin
                e1[k]   = ref_enc(p[8*k +: 8], disp[k]);
                disp[k] = disp[k] + 2 * $countones(e1[k]) - 10;
            end
            t1 = after_blank ? "R2 R3 R4 R6 R7 R10 R11" : "R2 R3 R4 R7 R10 R11";
            after_blank = 1'b0;
        end else begin
            for (int k = 0; k < 3; k++) disp[k] = 0;
            e1[0] = ref_ctl({vs, hs});
            e1[1] = ref_ctl(vs ? {c1, 1'b0} : 2'b00);
            e1[2] = ref_ctl(vs ? {1'b0, c2} : 2'b00);
            t1 = "R5 R8 R9 R10";
            after_blank = 1'b1;
        end
        rst = 1'b0; de = d; pix = p; hsync = hs; vsync = vs; ctl1 = c1; ctl2 = c2;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual still running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin e1[k] = ref_ctl(2'b00); e2[k] = ref_ctl(2'b00); end
        t1 = "R1"; t2 = "R1";
        repeat (3) @(negedge clk);
        chk("R1", 0, tx0, 10'b1101010100);
        chk("R1", 1, tx1, 10'b1101010100);
        chk("R1", 2, tx2, 10'b1101010100);

        // every byte on every lane in one long active run, sync toggling
        for (int i = 0; i < 256; i++)
            step(1'b1, {8'(i * 7 + 3), 8'(255 - i), 8'(i)}, i[0], i[1], i[2], i[3]);
        // every blanking combination, twice
        for (int i = 0; i < 32; i++)
            step(1'b0, 24'hA5A5A5, i[0], i[1], i[2], i[3]);
        // chopped runs with short blanks
        for (int i = 0; i < 400; i++)
            step(((i % 7) != 0) && ((i % 11) != 3), 24'(i * 40503 + i * i * 7),
                 i[1], i[2], i[3], i[4]);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule